// File: doc/BRIEF.md
# Toggle-Bit Circular Event Queue

This block is a single-producer, single-consumer ring of event slots kept in internal storage. The producer writes 31-bit event numbers one per cycle. Each slot carries one extra generation bit beside the payload. The producer stamps that bit with the inverse of its own lap toggle. The consumer compares it against its own lap toggle. Because of this, freshness is known from the slot alone, and no count is shared between the two sides. Both toggles flip each time their index wraps to zero.

The consumer issues either a consume request, which returns the entry and moves the read index forward, or a peek request, which returns the same entry and leaves the index and toggle untouched. A read finding no fresh entry reports empty with zero data. A disable input forces every read to report empty.

Beside the ring sits an admission counter, which limits how many occupants may be assigned to the queue. Releases are first collected in a separate pending counter. They are taken off the occupancy only when a read next sees the queue empty.

The read path is a two-state machine:
- IDLE accepts a request and moves to RESP.
- RESP presents the registered response for one cycle and returns to IDLE unconditionally.
- IDLE with no request stays in IDLE.

Top module: `evq_top`

## Requirements
- R1: After reset, rsp_valid is 0, occupancy and pending_release are 0, and every slot reads as empty.
- R2: A consume request on a fresh slot returns rsp_fresh=1 and the pushed 31-bit event number, with the generation bit stripped. Entries come back in push order.
- R3: A peek request returns the same data and freshness as a consume would. It changes neither the read index nor the consumer toggle, so a later consume returns the same entry.
- R4: A read finding no fresh slot returns rsp_fresh=0 and rsp_event=0, and does not move the read index.
- R5: The read index advances modulo DEPTH on each fresh consume, and the consumer toggle flips when it wraps to 0. The producer index and toggle behave the same way on pushes. Slots left over from the previous lap therefore read as empty.
- R6: A request accepted in IDLE yields rsp_valid high for exactly the following cycle, in RESP. Requests present during RESP are ignored.
- R7: When consume and peek are both asserted, the request is treated as a consume.
- R8: admit_ok is high only while occupancy is below DEPTH-1, so one slot always stays free. Each grant raises occupancy by one.
- R9: A release_req raises pending_release by one and leaves occupancy unchanged.
- R10: A read that reports empty with the queue enabled subtracts pending_release from occupancy and clears pending_release.
- R11: While q_disable is high, a read returns rsp_fresh=0 and data 0. It moves no index and leaves both counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Write one event into the next producer slot |
| push_event | input | EW | Event number to write |
| q_disable | input | 1 | Force reads to report empty |
| rd_consume | input | 1 | Read and advance request |
| rd_peek | input | 1 | Read without advancing request |
| rsp_valid | output | 1 | Response present (RESP state) |
| rsp_fresh | output | 1 | Response carries a new entry |
| rsp_event | output | EW | Returned event number, 0 when empty |
| admit_req | input | 1 | Ask to assign one more occupant |
| admit_ok | output | 1 | Admission granted this cycle |
| release_req | input | 1 | One occupant moved away |
| occupancy | output | CW | Current admission count |
| pending_release | output | CW | Releases not yet taken off occupancy |

## Verification
The hardest case to reach is a stale slot on a later lap: the slot still holds a payload whose generation bit matches the flipped consumer toggle. To get there, the stimulus pushes and drains one entry at a time through more than two full laps. An extra consume after each drain must report empty over stale contents. The deferred release is reached in a similar way. The stimulus first fills admission to its cap, then releases, then proves that a fresh read leaves occupancy alone. Only an empty read, and never a disabled one, folds the pending count away.

// File: rtl/evq_pkg.sv
package evq_pkg;
    typedef enum logic [0:0] {RD_IDLE, RD_RESP} rd_state_e;

    function automatic logic slot_is_new(input logic gen, input logic lap);
        return gen != lap;
    endfunction
endpackage

// File: rtl/evq_store.sv
module evq_store #(
    parameter int DEPTH = 8,
    parameter int EW    = 31,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [EW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic          rd_gen,
    output logic [EW-1:0] rd_payload
);
    logic [DEPTH-1:0] gen_q;
    logic [EW-1:0]    pay_q [DEPTH];
    logic [AW-1:0]    wr_idx_q;
    logic             plap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q    <= '0;
            wr_idx_q <= '0;
            plap_q   <= 1'b0;
        end else if (wr_en) begin
            gen_q[wr_idx_q] <= ~plap_q;
            wr_idx_q        <= wr_idx_q + 1'b1;
            if (wr_idx_q == AW'(DEPTH - 1))
                plap_q <= ~plap_q;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            pay_q[wr_idx_q] <= wr_data;
    end

    assign rd_gen     = gen_q[rd_idx];
    assign rd_payload = pay_q[rd_idx];

    assert_prod_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx_q == AW'(DEPTH - 1)) |=> (wr_idx_q == '0 && plap_q != $past(plap_q)));
endmodule

// File: rtl/evq_reader.sv
module evq_reader
    import evq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int EW    = 31,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_consume,
    input  logic          req_peek,
    input  logic          q_disable,
    input  logic          slot_gen,
    input  logic [EW-1:0] slot_payload,
    output logic [AW-1:0] rd_idx,
    output logic          rsp_valid,
    output logic          rsp_fresh,
    output logic [EW-1:0] rsp_data,
    output logic          empty_seen
);
    rd_state_e     state_q, state_d;
    logic [AW-1:0] idx_q;
    logic          clap_q;
    logic          accept, fresh_now, advance;

    assign accept     = (state_q == RD_IDLE) && (req_consume || req_peek);
    assign fresh_now  = !q_disable && slot_is_new(slot_gen, clap_q);
    assign advance    = accept && req_consume && fresh_now;
    assign empty_seen = accept && !q_disable && !fresh_now;
    assign rd_idx     = idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (accept) state_d = RD_RESP;
            RD_RESP: state_d = RD_IDLE;
        endcase
    end

    // State register with read index and consumer lap toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            idx_q   <= '0;
            clap_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (advance) begin
                idx_q <= idx_q + 1'b1;
                if (idx_q == AW'(DEPTH - 1))
                    clap_q <= ~clap_q;
            end
        end
    end

    // Registered response outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fresh <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_fresh <= accept && fresh_now;
            rsp_data  <= (accept && fresh_now) ? slot_payload : '0;
        end
    end

    assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_empty_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fresh) |-> (rsp_data == '0));
    assert_peek_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_IDLE && req_peek && !req_consume) |=> ($stable(idx_q) && $stable(clap_q)));
    assert_cons_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && idx_q == AW'(DEPTH - 1)) |=> (idx_q == '0 && clap_q != $past(clap_q)));
    assert_disable_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_IDLE && (req_consume || req_peek) && q_disable)
        |=> (rsp_valid && !rsp_fresh && rsp_data == '0 && $stable(idx_q)));
endmodule

// File: rtl/evq_admit.sv
module evq_admit #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          admit_req,
    input  logic          release_req,
    input  logic          flush,
    output logic          admit_ok,
    output logic [CW-1:0] occupancy,
    output logic [CW-1:0] pending
);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH - 1);
    localparam logic [CW-1:0] PMAX = {CW{1'b1}};

    logic [CW-1:0] occ_q, pend_q, occ_left, pend_base;

    assign admit_ok  = admit_req && (occ_q < CAP);
    assign occ_left  = !flush ? occ_q : ((pend_q > occ_q) ? '0 : occ_q - pend_q);
    assign pend_base = flush ? '0 : pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q  <= '0;
            pend_q <= '0;
        end else begin
            occ_q  <= occ_left + CW'(admit_ok);
            pend_q <= pend_base + CW'(release_req && pend_base != PMAX);
        end
    end

    assign occupancy = occ_q;
    assign pending   = pend_q;

    assert_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= CAP);
    assert_no_early_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !admit_req) |=> $stable(occ_q));
    assert_flush_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !release_req) |=> (pend_q == '0));
endmodule

// File: rtl/evq_top.sv
module evq_top #(
    parameter int DEPTH = 8,
    parameter int EW    = 31,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [EW-1:0] push_event,
    input  logic          q_disable,
    input  logic          rd_consume,
    input  logic          rd_peek,
    output logic          rsp_valid,
    output logic          rsp_fresh,
    output logic [EW-1:0] rsp_event,
    input  logic          admit_req,
    output logic          admit_ok,
    input  logic          release_req,
    output logic [CW-1:0] occupancy,
    output logic [CW-1:0] pending_release
);
    logic [AW-1:0] rd_idx;
    logic          slot_gen, empty_seen;
    logic [EW-1:0] slot_payload;

    evq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(push_valid), .wr_data(push_event),
        .rd_idx(rd_idx), .rd_gen(slot_gen), .rd_payload(slot_payload)
    );

    evq_reader #(.DEPTH(DEPTH), .EW(EW)) u_reader (
        .clk(clk), .rst_n(rst_n),
        .req_consume(rd_consume), .req_peek(rd_peek), .q_disable(q_disable),
        .slot_gen(slot_gen), .slot_payload(slot_payload),
        .rd_idx(rd_idx), .rsp_valid(rsp_valid), .rsp_fresh(rsp_fresh),
        .rsp_data(rsp_event), .empty_seen(empty_seen)
    );

    evq_admit #(.DEPTH(DEPTH)) u_admit (
        .clk(clk), .rst_n(rst_n),
        .admit_req(admit_req), .release_req(release_req), .flush(empty_seen),
        .admit_ok(admit_ok), .occupancy(occupancy), .pending(pending_release)
    );
endmodule

// File: tb/evq_top_tb.sv
module evq_top_tb;
    localparam int DEPTH = 8;
    localparam int EW    = 31;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_valid = 1'b0;
    logic [EW-1:0] push_event = '0;
    logic          q_disable = 1'b0;
    logic          rd_consume = 1'b0;
    logic          rd_peek = 1'b0;
    logic          rsp_valid, rsp_fresh, admit_ok;
    logic [EW-1:0] rsp_event;
    logic          admit_req = 1'b0;
    logic          release_req = 1'b0;
    logic [CW-1:0] occupancy, pending_release;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    evq_top #(.DEPTH(DEPTH), .EW(EW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_event(push_event), .q_disable(q_disable),
        .rd_consume(rd_consume), .rd_peek(rd_peek),
        .rsp_valid(rsp_valid), .rsp_fresh(rsp_fresh), .rsp_event(rsp_event),
        .admit_req(admit_req), .admit_ok(admit_ok), .release_req(release_req),
        .occupancy(occupancy), .pending_release(pending_release)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [EW-1:0] v);
        @(negedge clk);
        push_valid = 1'b1;
        push_event = v;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic do_read(input logic cons, input logic pk, input logic exp_fresh,
                           input logic [EW-1:0] exp_data, input string req);
        @(negedge clk);
        rd_consume = cons;
        rd_peek    = pk;
        @(negedge clk);
        rd_consume = 1'b0;
        rd_peek    = 1'b0;
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " fresh"}, 32'(rsp_fresh), 32'(exp_fresh));
        check({req, " data"}, 32'(rsp_event), 32'(exp_data));
    endtask

    task automatic t_reset;
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 occupancy", 32'(occupancy), 32'd0);
        check("R1 pending", 32'(pending_release), 32'd0);
        do_read(1'b0, 1'b1, 1'b0, '0, "R1 peek empty");
        do_read(1'b1, 1'b0, 1'b0, '0, "R4 consume empty");
    endtask

    task automatic t_fifo;
        push(31'h7FFF_FFFF);
        push(31'h0000_0001);
        push(31'h1234_5678);
        do_read(1'b1, 1'b0, 1'b1, 31'h7FFF_FFFF, "R2 first");
        do_read(1'b1, 1'b0, 1'b1, 31'h0000_0001, "R2 second");
        do_read(1'b1, 1'b0, 1'b1, 31'h1234_5678, "R2 third");
        do_read(1'b1, 1'b0, 1'b0, '0, "R4 drained");
    endtask

    task automatic t_peek;
        push(31'h0ABC_DEF0);
        do_read(1'b0, 1'b1, 1'b1, 31'h0ABC_DEF0, "R3 peek1");
        do_read(1'b0, 1'b1, 1'b1, 31'h0ABC_DEF0, "R3 peek2");
        do_read(1'b1, 1'b0, 1'b1, 31'h0ABC_DEF0, "R3 consume after peek");
        do_read(1'b0, 1'b1, 1'b0, '0, "R3 peek empty");
    endtask

    task automatic t_both;
        push(31'h111);
        push(31'h222);
        do_read(1'b1, 1'b1, 1'b1, 31'h111, "R7 both");
        do_read(1'b1, 1'b0, 1'b1, 31'h222, "R7 next");
    endtask

    task automatic t_hold;
        push(31'h333);
        push(31'h444);
        @(negedge clk);
        rd_consume = 1'b1;
        @(negedge clk);
        check("R6 resp valid", 32'(rsp_valid), 32'd1);
        check("R6 resp data", 32'(rsp_event), 32'h333);
        @(negedge clk);
        rd_consume = 1'b0;
        check("R6 single pulse", 32'(rsp_valid), 32'd0);
        do_read(1'b1, 1'b0, 1'b1, 31'h444, "R6 held request ignored");
    endtask

    task automatic t_wrap;
        for (int i = 0; i < 2 * DEPTH + 3; i++) begin
            push(EW'(32'h500 + i));
            do_read(1'b1, 1'b0, 1'b1, EW'(32'h500 + i), "R5 lap entry");
            do_read(1'b1, 1'b0, 1'b0, '0, "R5 stale slot empty");
        end
    endtask

    task automatic t_admit;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            admit_req = 1'b1;
            #1;
            check("R8 grant", 32'(admit_ok), (i < DEPTH - 1) ? 32'd1 : 32'd0);
            @(negedge clk);
            admit_req = 1'b0;
        end
        check("R8 occupancy capped", 32'(occupancy), 32'(DEPTH - 1));
        @(negedge clk);
        release_req = 1'b1;
        @(negedge clk);
        release_req = 1'b0;
        check("R9 pending", 32'(pending_release), 32'd1);
        check("R9 occupancy kept", 32'(occupancy), 32'(DEPTH - 1));
        push(31'h777);
        do_read(1'b1, 1'b0, 1'b1, 31'h777, "R10 fresh read");
        check("R10 no flush on fresh", 32'(occupancy), 32'(DEPTH - 1));
        do_read(1'b0, 1'b1, 1'b0, '0, "R10 empty peek");
        check("R10 occupancy reduced", 32'(occupancy), 32'(DEPTH - 2));
        check("R10 pending cleared", 32'(pending_release), 32'd0);
        @(negedge clk);
        admit_req = 1'b1;
        #1;
        check("R8 grant after release", 32'(admit_ok), 32'd1);
        @(negedge clk);
        admit_req = 1'b0;
    endtask

    task automatic t_disable;
        @(negedge clk);
        release_req = 1'b1;
        @(negedge clk);
        release_req = 1'b0;
        push(31'h0F0F);
        q_disable = 1'b1;
        do_read(1'b1, 1'b0, 1'b0, '0, "R11 disabled consume");
        do_read(1'b0, 1'b1, 1'b0, '0, "R11 disabled peek");
        check("R11 pending kept", 32'(pending_release), 32'd1);
        check("R11 occupancy kept", 32'(occupancy), 32'(DEPTH - 1));
        q_disable = 1'b0;
        do_read(1'b1, 1'b0, 1'b1, 31'h0F0F, "R11 index unchanged");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_admit();
        t_disable();
        t_fifo();
        t_peek();
        t_both();
        t_hold();
        t_wrap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule